// File: doc/BRIEF.md
# Read-Cycle Write Decoder for a ROM Expansion Port

A ROM expansion port has an address bus and a read strobe but no read/write line. This block lets a peripheral on such a port accept writes anyway. The host writes by reading from chosen addresses. The block watches the 14-bit port address and the read strobe. For a write access it latches a data byte, and for the index variant a register index, then emits a one-clock write pulse. For any other read it raises the ROM output enable, so conventional ROM devices keep working beside the peripheral.

A build-time parameter picks one of two address conventions. In window mode, the highest 256 bytes of the port space (0x3F00 to 0x3FFF) are a write window, and the low address byte carries the data. In split mode, address bit 13 is the direction flag, so every write address equals its read twin plus 0x2000 and the readable space is halved. Bits 12:8 give a register index and bits 7:0 the data.

The read strobe passes through a two-flop synchroniser. A four-state controller then turns each qualifying strobe into exactly one write. Its states are IDLE, READ, WRITE and HOLD. The transitions are:
- IDLE→WRITE when the strobe is seen with a write address.
- IDLE→READ when the strobe is seen with any other address.
- READ→IDLE on strobe release.
- WRITE→HOLD while the strobe stays high, or WRITE→IDLE if it has already gone.
- HOLD→IDLE on strobe release.

Top module: `romport_write_decoder`

## Requirements
- R1: While reset is low, and at the first clock after it is released, `wr_data` and `wr_index` are zero, `wr_strobe` is low and `rom_oe` is low.
- R2: In window mode, a read at an address whose bits 13:8 are all ones (0x3F00–0x3FFF) produces one write pulse, with `wr_data` equal to address bits 7:0 and `wr_index` equal to zero.
- R3: In window mode, a read at any address below 0x3F00 produces no write pulse, leaves `wr_data` unchanged and drives `rom_oe` high while the read strobe is high.
- R4: In split mode, a read with address bit 13 low is an ordinary read: `rom_oe` is high during the strobe and no write pulse occurs.
- R5: In split mode, a read with address bit 13 high produces one write pulse, with `wr_data` equal to address bits 7:0 and `wr_index` equal to address bits 12:8.
- R6: `wr_strobe` is high for exactly one clock per qualifying read strobe, however long the strobe is held. A strobe that is released and asserted again produces a fresh pulse.
- R7: `rom_oe` is low whenever the read strobe is low, and it stays low throughout a recognised write access.
- R8: `wr_data` and `wr_index` change only in the cycle in which `wr_strobe` is high.
- R9: With the read strobe and address changed just after a clock edge, `wr_strobe` is first high after the third following rising edge (two synchroniser stages plus the state register).
- R10: In window mode, 0x3EFF is an ordinary read, while 0x3F00 and 0x3FFF are writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_addr | input | 14 | Expansion port address bus |
| port_rd | input | 1 | Port read strobe, active high, asynchronous to clk |
| wr_strobe | output | 1 | One-clock write pulse to the peripheral |
| wr_data | output | 8 | Latched write data byte |
| wr_index | output | 5 | Latched write register index (zero in window mode) |
| rom_oe | output | 1 | ROM output enable for ordinary reads |

## Verification
One bench instance is built in window mode and one in split mode, and both see the same access sequence. The addresses include:
- low ROM addresses, which neither mode treats as writes;
- addresses in 0x2000–0x3EFF, which only split mode treats as writes, so the two conventions are told apart;
- the window edges 0x3EFF, 0x3F00 and 0x3FFF, which expose an off-by-one in the base comparison;
- varied low bytes and index bits, which expose swapped or shifted data fields.

Directed runs add a long-held strobe, back-to-back strobes with a short gap, a latency count and a reset in the middle of traffic.

// File: rtl/romwr_pkg.sv
`timescale 1ns/1ps
package romwr_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        MODE_WINDOW = 1'b0,
        MODE_SPLIT  = 1'b1
    } port_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_HOLD  = 2'd3
    } wr_state_e;

endpackage

// File: rtl/romwr_sync.sv
`timescale 1ns/1ps
module romwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/romwr_addr_decode.sv
`timescale 1ns/1ps
module romwr_addr_decode
    import romwr_pkg::*;
#(
    parameter int         ADDR_W = 14,
    parameter int         IDX_W  = 5,
    parameter port_mode_e MODE   = MODE_WINDOW
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_write,
    output logic [BYTE_W-1:0] data_field,
    output logic [IDX_W-1:0]  index_field
);
    assign data_field = addr[BYTE_W-1:0];

    generate
        if (MODE == MODE_SPLIT) begin : g_split
            // Top line is the direction flag; bits between flag and data byte are the index.
            assign is_write    = addr[ADDR_W-1];
            assign index_field = addr[ADDR_W-2:BYTE_W];
        end else begin : g_window
            // Window occupies the last 256 bytes: every bit above the data byte set.
            assign is_write    = &addr[ADDR_W-1:BYTE_W];
            assign index_field = '0;
        end
    endgenerate
endmodule

// File: rtl/romwr_fsm.sv
`timescale 1ns/1ps
module romwr_fsm
    import romwr_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sync,
    input  logic              is_write,
    input  logic [BYTE_W-1:0] data_in,
    input  logic [IDX_W-1:0]  index_in,
    output logic              wr_strobe,
    output logic [BYTE_W-1:0] wr_data,
    output logic [IDX_W-1:0]  wr_index
);
    wr_state_e state_q, state_nx;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (rd_sync) state_nx = is_write ? ST_WRITE : ST_READ;
            ST_READ:  if (!rd_sync) state_nx = ST_IDLE;
            ST_WRITE: state_nx = rd_sync ? ST_HOLD : ST_IDLE;
            ST_HOLD:  if (!rd_sync) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Output latch: captured on entry to WRITE only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_data  <= '0;
            wr_index <= '0;
        end else if (state_nx == ST_WRITE) begin
            wr_data  <= data_in;
            wr_index <= index_in;
        end
    end

    assign wr_strobe = (state_q == ST_WRITE);
endmodule

// File: rtl/romport_write_decoder.sv
`timescale 1ns/1ps
module romport_write_decoder
    import romwr_pkg::*;
#(
    parameter int         ADDR_W      = 14,
    parameter int         SYNC_STAGES = 2,
    parameter port_mode_e MODE        = MODE_WINDOW,
    localparam int        IDX_W       = ADDR_W - 1 - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic              port_rd,
    output logic              wr_strobe,
    output logic [BYTE_W-1:0] wr_data,
    output logic [IDX_W-1:0]  wr_index,
    output logic              rom_oe
);
    logic              rd_sync;
    logic              addr_is_write;
    logic [BYTE_W-1:0] addr_data;
    logic [IDX_W-1:0]  addr_index;

    romwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (port_rd),
        .q_sync  (rd_sync)
    );

    romwr_addr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .MODE(MODE)) u_dec (
        .addr        (port_addr),
        .is_write    (addr_is_write),
        .data_field  (addr_data),
        .index_field (addr_index)
    );

    romwr_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_sync   (rd_sync),
        .is_write  (addr_is_write),
        .data_in   (addr_data),
        .index_in  (addr_index),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .wr_index  (wr_index)
    );

    // ROM drives the bus only for ordinary reads
    assign rom_oe = port_rd & ~addr_is_write;
endmodule

// File: rtl/romwr_checker.sv
`timescale 1ns/1ps
module romwr_checker #(
    parameter int DW = 8,
    parameter int IW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          port_rd,
    input logic          rom_oe,
    input logic          wr_strobe,
    input logic [DW-1:0] wr_data,
    input logic [IW-1:0] wr_index
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (wr_data == '0 && wr_index == '0 && !wr_strobe));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

    assert_oe_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !port_rd |-> !rom_oe);

    assert_oe_off_in_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> !rom_oe);

    assert_latch_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe |-> ($stable(wr_data) && $stable(wr_index)));
endmodule

bind romport_write_decoder romwr_checker #(.DW(romwr_pkg::BYTE_W), .IW(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_rd   (port_rd),
    .rom_oe    (rom_oe),
    .wr_strobe (wr_strobe),
    .wr_data   (wr_data),
    .wr_index  (wr_index)
);

// File: tb/test_romport_write_decoder.sv
`timescale 1ns/1ps
module test_romport_write_decoder;
    import romwr_pkg::*;

    localparam int AW = 14;
    localparam int IW = 5;
    localparam int NV = 10;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          win_wr;
        logic          split_wr;
    } vec_t;

    // addr, window-mode write?, split-mode write?
    localparam vec_t VECS [NV] = '{
        '{14'h0000, 1'b0, 1'b0},
        '{14'h1234, 1'b0, 1'b0},
        '{14'h2000, 1'b0, 1'b1},
        '{14'h3EFF, 1'b0, 1'b1},
        '{14'h3F00, 1'b1, 1'b1},
        '{14'h3FA5, 1'b1, 1'b1},
        '{14'h1FFF, 1'b0, 1'b0},
        '{14'h2B5C, 1'b0, 1'b1},
        '{14'h3FFF, 1'b1, 1'b1},
        '{14'h3E80, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          port_rd;
    logic [AW-1:0] port_addr;
    logic          w_stb, s_stb, w_oe, s_oe;
    logic [7:0]    w_data, s_data;
    logic [IW-1:0] w_idx, s_idx;

    int n_cmp = 0;
    int n_bad = 0;

    romport_write_decoder #(.MODE(MODE_WINDOW)) i_romport_write_decoder (
        .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .port_rd(port_rd),
        .wr_strobe(w_stb), .wr_data(w_data), .wr_index(w_idx), .rom_oe(w_oe));

    romport_write_decoder #(.MODE(MODE_SPLIT)) i_romport_write_decoder_split (
        .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .port_rd(port_rd),
        .wr_strobe(s_stb), .wr_data(s_data), .wr_index(s_idx), .rom_oe(s_oe));

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // One port read; counts pulses on both instances and notes first pulse cycle
    task automatic access(input logic [AW-1:0] a, input int hold,
                          output int wc, output int sc, output int wfirst,
                          output logic woe, output logic soe);
        wc = 0; sc = 0; wfirst = -1; woe = 1'b0; soe = 1'b0;
        @(negedge clk);
        port_addr = a;
        port_rd   = 1'b1;
        for (int i = 1; i <= hold; i++) begin
            @(negedge clk);
            if (i == 1) begin woe = w_oe; soe = s_oe; end
            if (w_stb) begin wc++; if (wfirst < 0) wfirst = i; end
            if (s_stb) sc++;
        end
        port_rd = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (w_stb) wc++;
            if (s_stb) sc++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R6 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int wc, sc, wf;
        logic woe, soe;
        logic [7:0]    ew_data, es_data;
        logic [IW-1:0] es_idx;

        rst_n = 1'b0; port_rd = 1'b0; port_addr = '0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1", "win data", w_data, 0);
        chk("R1", "split idx", s_idx, 0);
        chk("R1", "strobes", {w_stb, s_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "after release data", {w_data, s_data}, 0);
        chk("R7", "oe idle", {w_oe, s_oe}, 0);

        ew_data = '0; es_data = '0; es_idx = '0;
        for (int v = 0; v < NV; v++) begin
            access(VECS[v].addr, 8, wc, sc, wf, woe, soe);
            if (VECS[v].win_wr) ew_data = VECS[v].addr[7:0];
            if (VECS[v].split_wr) begin
                es_data = VECS[v].addr[7:0];
                es_idx  = VECS[v].addr[12:8];
            end
            // R2/R3/R10 window mode, R4/R5 split mode
            chk(VECS[v].win_wr ? "R2" : "R3", "win pulses", wc, VECS[v].win_wr ? 1 : 0);
            chk(VECS[v].win_wr ? "R2" : "R3", "win data", w_data, ew_data);
            chk("R2", "win index zero", w_idx, 0);
            chk("R7", "win oe", woe, VECS[v].win_wr ? 0 : 1);
            chk(VECS[v].split_wr ? "R5" : "R4", "split pulses", sc, VECS[v].split_wr ? 1 : 0);
            chk("R5", "split data", s_data, es_data);
            chk("R5", "split index", s_idx, es_idx);
            chk("R4", "split oe", soe, VECS[v].split_wr ? 0 : 1);
        end

        // R10 window edges explicitly
        access(14'h3EFF, 8, wc, sc, wf, woe, soe);
        chk("R10", "0x3EFF not a write", wc, 0);
        access(14'h3F00, 8, wc, sc, wf, woe, soe);
        chk("R10", "0x3F00 is a write", wc, 1);

        // R9 latency
        access(14'h3F42, 8, wc, sc, wf, woe, soe);
        chk("R9", "first pulse cycle", wf, 3);
        chk("R8", "data after write", w_data, 8'h42);

        // R6 long strobe gives one pulse
        access(14'h3FC3, 40, wc, sc, wf, woe, soe);
        chk("R6", "long hold win", wc, 1);
        chk("R6", "long hold split", sc, 1);

        // R6 re-assert after short gap gives a fresh pulse each time
        @(negedge clk);
        port_addr = 14'h3F11; port_rd = 1'b1;
        repeat (5) @(negedge clk);
        port_rd = 1'b0;
        @(negedge clk);
        port_addr = 14'h3F22; port_rd = 1'b1;
        wc = 0;
        repeat (6) begin @(negedge clk); if (w_stb) wc++; end
        port_rd = 1'b0;
        repeat (5) begin @(negedge clk); if (w_stb) wc++; end
        chk("R6", "second pulse after gap", wc, 1);
        chk("R6", "second data", w_data, 8'h22);

        // R8 ordinary read keeps latch
        access(14'h0155, 8, wc, sc, wf, woe, soe);
        chk("R8", "read keeps win data", w_data, 8'h22);

        // R1 reset mid traffic
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "mid reset data", {w_data, s_data}, 0);
        chk("R1", "mid reset idx", s_idx, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        summary();
        $finish;
    end
endmodule